// File: doc/BRIEF.md
# Coprocessor Error Interrupt Controller

This block turns a floating-point coprocessor's error indication into an interrupt request for the host CPU. It also lets software acknowledge the error. The coprocessor signals an error on an active-low input. When error reporting is enabled by a separate mode bit, the block raises the line-13 interrupt request for as long as the error is pending.

Software acknowledges the error by performing an I/O write to port F0h. If that write arrives while the error is asserted, the block withdraws the interrupt request. In its place it drives an active-low "ignore numeric error" output to the CPU. That output is sticky: it holds until the coprocessor releases its error line.

The error input comes from another timing domain, so it passes through a synchronizer before any decision is made. The acknowledge path, the port decoder and the mode bit are all synchronous to the block clock.

Top module: `fperr_irq_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `irq13` is 0 and `ignne_n` is 1.
- R2: With `mode_en` = 1, an error (`err_n` = 0) raises `irq13` on the third rising clock edge after `err_n` is first sampled low, and not before. The three edges are two synchronizer stages plus the state register.
- R3: With `mode_en` = 0, `irq13` stays 0 and `ignne_n` stays 1 whatever `err_n` does, and writes to port F0h have no effect.
- R4: With `mode_en` = 1 and the synchronized error asserted, a write (`io_wr` = 1) with `io_addr` = 8'hF0 drives `ignne_n` to 0 and `irq13` to 0 on the next rising edge. `irq13` and an asserted ignore output are never high and low respectively at the same time.
- R5: Once `ignne_n` is 0, it stays 0 until `err_n` returns high. It then rises on the third rising edge after `err_n` is sampled high.
- R6: A write to port F0h while the synchronized error is not asserted leaves `ignne_n` at 1.
- R7: A write to any address other than 8'hF0 changes neither `irq13` nor `ignne_n`.
- R8: After an acknowledge, `irq13` does not rise again until the error has been seen negated and then asserted anew. This holds even if the mode bit is toggled in between.
- R9: Clearing `mode_en` while `ignne_n` is 0 releases it, together with `irq13`, on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_addr | input | 8 | I/O address of the write |
| err_n | input | 1 | Coprocessor error, active low, asynchronous |
| mode_en | input | 1 | Error-reporting mode enable |
| irq13 | output | 1 | Interrupt request, line 13, active high |
| ignne_n | output | 1 | Ignore numeric error to the CPU, active low |

## Verification
The properties are written against the synchronized error level, not the raw pin. They therefore take for granted that `err_n` settles well within a clock period and holds long enough to cross both synchronizer stages. They also assume that `mode_en`, `io_wr` and `io_addr` are synchronous to `clk`. The stimulus respects this by changing every input only on the falling edge. It holds each error level for at least three cycles before the outputs are judged, and issues each write as a one-cycle strobe.

// File: rtl/fperr_pkg.sv
package fperr_pkg;

    typedef struct packed {
        logic irq;    // interrupt request toward the CPU
        logic ign;    // ignore-error held (output is its inverse)
        logic armed;  // a fresh error may raise the interrupt
    } fperr_state_t;

    localparam fperr_state_t FPERR_STATE_RST = '{irq: 1'b0, ign: 1'b0, armed: 1'b1};

endpackage

// File: rtl/fperr_sync.sv
module fperr_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/fperr_port_decode.sv
module fperr_port_decode #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 8'hF0
) (
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              hit
);
    always_comb hit = io_wr && (io_addr == PORT_ADDR);
endmodule

// File: rtl/fperr_core.sv
module fperr_core
    import fperr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic err_act,
    input  logic mode_en,
    input  logic port_hit,
    output logic irq,
    output logic ign
);
    fperr_state_t st_d, st_q;
    logic         ack;

    always_comb begin
        ack  = mode_en && err_act && port_hit;
        st_d = st_q;

        // re-arm only once the error has been seen released
        if (!err_act)  st_d.armed = 1'b1;
        else if (ack)  st_d.armed = 1'b0;

        if (!mode_en || !err_act) begin
            st_d.irq = 1'b0;
            st_d.ign = 1'b0;
        end else if (ack) begin
            st_d.irq = 1'b0;
            st_d.ign = 1'b1;
        end else if (st_q.ign) begin
            st_d.irq = 1'b0;
        end else begin
            st_d.irq = st_q.armed;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= FPERR_STATE_RST;
        else     st_q <= st_d;
    end

    assign irq = st_q.irq;
    assign ign = st_q.ign;
endmodule

// File: rtl/fperr_irq_ctrl.sv
module fperr_irq_ctrl #(
    parameter int         ADDR_W      = 8,
    parameter logic [7:0] PORT_ADDR   = 8'hF0,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              err_n,
    input  logic              mode_en,
    output logic              irq13,
    output logic              ignne_n
);
    localparam logic [ADDR_W-1:0] DEC_ADDR = ADDR_W'(PORT_ADDR);

    logic err_n_s;
    logic err_act;
    logic port_hit;
    logic ign;

    fperr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (err_n),
        .dout(err_n_s)
    );

    assign err_act = ~err_n_s;

    fperr_port_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(DEC_ADDR)) u_dec (
        .io_wr  (io_wr),
        .io_addr(io_addr),
        .hit    (port_hit)
    );

    fperr_core u_core (
        .clk     (clk),
        .rst     (rst),
        .err_act (err_act),
        .mode_en (mode_en),
        .port_hit(port_hit),
        .irq     (irq13),
        .ign     (ign)
    );

    assign ignne_n = ~ign;
endmodule

// File: rtl/fperr_irq_ctrl_chk.sv
module fperr_irq_ctrl_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 8'hF0
) (
    input logic              clk,
    input logic              rst,
    input logic              io_wr,
    input logic [ADDR_W-1:0] io_addr,
    input logic              err_act,
    input logic              mode_en,
    input logic              irq13,
    input logic              ignne_n
);
    logic hit;
    assign hit = io_wr && (io_addr == PORT_ADDR);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!irq13 && ignne_n)); // R1

    AST_IRQ_NEEDS_ERR: assert property (@(posedge clk) disable iff (rst)
        $rose(irq13) |-> ($past(err_act) && $past(mode_en))); // R2

    AST_MODE_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        !mode_en |=> (!irq13 && ignne_n)); // R3

    AST_ACK_SWAP: assert property (@(posedge clk) disable iff (rst)
        (mode_en && err_act && hit) |=> (!ignne_n && !irq13)); // R4

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(irq13 && !ignne_n)); // R4

    AST_IGN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (mode_en && err_act && !ignne_n) |=> !ignne_n); // R5

    AST_IGN_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        (ignne_n && !(mode_en && err_act && hit)) |=> ignne_n); // R6

    AST_MODE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!ignne_n && !mode_en) |=> ignne_n); // R9
endmodule

bind fperr_irq_ctrl fperr_irq_ctrl_chk #(.ADDR_W(ADDR_W), .PORT_ADDR(DEC_ADDR)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .io_wr  (io_wr),
    .io_addr(io_addr),
    .err_act(err_act),
    .mode_en(mode_en),
    .irq13  (irq13),
    .ignne_n(ignne_n)
);

// File: tb/fperr_irq_ctrl_test.sv
module fperr_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] ACK_PORT = 8'hF0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_wr = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       err_n = 1'b1;
    logic       mode_en = 1'b0;
    logic       irq13;
    logic       ignne_n;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fperr_irq_ctrl uut (
        .clk    (clk),
        .rst    (rst),
        .io_wr  (io_wr),
        .io_addr(io_addr),
        .err_n  (err_n),
        .mode_en(mode_en),
        .irq13  (irq13),
        .ignne_n(ignne_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic exp_irq, input logic exp_ign_n);
        checks++;
        if (irq13 !== exp_irq || ignne_n !== exp_ign_n) begin
            fails++;
            $display("FAIL %s: irq13=%b ignne_n=%b expected irq13=%b ignne_n=%b",
                     req, irq13, ignne_n, exp_irq, exp_ign_n);
        end
    endtask

    task automatic wr_port(input logic [7:0] a);
        io_wr = 1'b1;
        io_addr = a;
        tick(1);
        io_wr = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
    end

    initial begin
        tick(3);
        expect_out("R1 during reset", 1'b0, 1'b1);
        rst = 1'b0;
        tick(1);
        expect_out("R1 after reset", 1'b0, 1'b1);

        // mode off: error and writes ignored
        err_n = 1'b0;
        tick(5);
        expect_out("R3 error with mode off", 1'b0, 1'b1);
        wr_port(ACK_PORT);
        expect_out("R3 write with mode off", 1'b0, 1'b1);

        // enabling with error already synchronized: one edge
        mode_en = 1'b1;
        tick(1);
        expect_out("R2 enable with pending error", 1'b1, 1'b1);

        wr_port(ACK_PORT);
        expect_out("R4 acknowledge", 1'b0, 1'b0);
        tick(10);
        expect_out("R5 hold while error", 1'b0, 1'b0);
        err_n = 1'b1;
        tick(2);
        expect_out("R5 still held before sync", 1'b0, 1'b0);
        tick(1);
        expect_out("R5 release", 1'b0, 1'b1);

        wr_port(ACK_PORT);
        expect_out("R6 write without error", 1'b0, 1'b1);
        tick(2);
        expect_out("R6 later", 1'b0, 1'b1);

        // exact latency of a new error
        err_n = 1'b0;
        tick(2);
        expect_out("R2 before third edge", 1'b0, 1'b1);
        tick(1);
        expect_out("R2 third edge", 1'b1, 1'b1);

        wr_port(8'hF1);
        expect_out("R7 neighbour address", 1'b1, 1'b1);

        // acknowledge, then drop the mode
        wr_port(ACK_PORT);
        expect_out("R4 second acknowledge", 1'b0, 1'b0);
        mode_en = 1'b0;
        tick(1);
        expect_out("R9 mode cleared releases", 1'b0, 1'b1);
        mode_en = 1'b1;
        tick(3);
        expect_out("R8 no re-raise from stale error", 1'b0, 1'b1);
        err_n = 1'b1;
        tick(3);
        err_n = 1'b0;
        tick(3);
        expect_out("R8 re-raise after fresh error", 1'b1, 1'b1);

        // sweep every address with the error pending
        for (int a = 0; a < 256; a++) begin
            logic is_ack;
            is_ack = (a[7:0] == ACK_PORT);
            wr_port(a[7:0]);
            if (is_ack) expect_out("R4 sweep acknowledge", 1'b0, 1'b0);
            else        expect_out("R7 sweep other address", 1'b1, 1'b1);
            if (is_ack) begin
                err_n = 1'b1;
                tick(3);
                expect_out("R5 sweep release", 1'b0, 1'b1);
                err_n = 1'b0;
                tick(3);
                expect_out("R2 sweep re-raise", 1'b1, 1'b1);
            end
        end

        // sweep every address with no error pending
        err_n = 1'b1;
        tick(3);
        for (int a = 0; a < 256; a++) begin
            wr_port(a[7:0]);
            expect_out("R6 sweep no error", 1'b0, 1'b1);
        end

        summary();
    end
endmodule